// File: doc/BRIEF.md
# Read-Only Instruction Fetch Cache

This block sits between a processor's instruction-fetch port and the next memory level. It is direct-mapped and never writes. The number of lines and the line size are parameters. A fetch that hits returns its word on the next cycle and causes no bus traffic. A fetch that misses reads the whole aligned line from the bus, one word at a time, and then answers with the word that was asked for.

Fetches at or above the fixed I/O base at 0xF0000000 are never cached. Each one becomes a single bus read at its exact address. A one-cycle clear pulse, raised when the processor executes an instruction fence, drops every line so that later fetches reload from memory. If the bus reports an error while a line is being filled, the fill stops, the line is left invalid and the fetch returns with its error flag set.

The fetch side takes one request at a time. A request is accepted in a cycle where `f_req` and `f_ready` are both high. The bus side holds `bus_req` and `bus_addr` steady until the bus answers with `bus_ack` or `bus_err` for one cycle.

Top module: `ifetch_cache`

## Requirements
- R1: A fetch that hits sets `f_rvalid` exactly one cycle after it is accepted, with the stored word, and raises no `bus_req`. `f_rvalid` is never high without an accepted request before it.
- R2: A fetch that misses reads every word of its aligned line, in ascending address order from the line base, on word-aligned bus addresses. `bus_addr` stays stable until the bus answers. The response comes after the last word and carries the requested word.
- R3: After a successful fill, a fetch of any other word of the same line hits.
- R4: Line index bits are address bits [log2(line bytes) +: log2(lines)], and the remaining upper bits are the tag. A fetch with the same index and a different tag replaces the line, so the old address misses again afterwards.
- R5: A fetch at an address at or above 0xF0000000 makes exactly one bus read at that exact address and returns the bus data. It never allocates a line, so repeating it reads the bus again.
- R6: A `clr` pulse while idle invalidates every line, so the next fetch of a previously cached address misses.
- R7: A `clr` pulse during a fill does not disturb that fill or its response. The clear takes effect once the fill ends, and the freshly filled line is invalid afterwards.
- R8: A `bus_err` during a fill ends the fill at that word. The fetch returns with `f_rerr` high together with `f_rvalid`, and the line is invalid, so a later fetch to it goes to the bus again.
- R9: A `bus_err` on an uncached read returns with `f_rerr` high.
- R10: After reset `f_ready` is high and `f_rvalid` and `bus_req` are low. `f_ready` stays low while any bus read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Invalidate-all pulse (instruction fence) |
| f_req | input | 1 | Fetch request |
| f_addr | input | ADDR_W | Fetch byte address |
| f_ready | output | 1 | Cache can accept a fetch |
| f_rvalid | output | 1 | Fetch response valid (one cycle) |
| f_rdata | output | DATA_W | Fetch response word |
| f_rerr | output | 1 | Fetch response carries a bus error |
| bus_req | output | 1 | Bus read request, held until answered |
| bus_addr | output | ADDR_W | Bus read address |
| bus_rdata | input | DATA_W | Bus read data |
| bus_ack | input | 1 | Bus read completed |
| bus_err | input | 1 | Bus read failed |

## Verification
A cold fetch, then a fetch of a neighbouring word of the same line, separates the fill path from the hit path by latency and by bus activity. A fetch that shares an index but not a tag shows whether the line is really replaced. Repeated fetches in the I/O window, with the bus answering after zero or several wait cycles, show whether such reads are ever allocated. Clear pulses sent while idle and in the middle of a fill, and bus errors planted on a chosen word of a line or on an uncached address, show whether invalidation happens at the right moment and whether an aborted fill leaves anything valid behind.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_FILL   = 2'd1,
      ST_DIRECT = 2'd2
   } ifc_state_e;
endpackage

// File: rtl/ifc_tag_array.sv
module ifc_tag_array #(
   parameter int NUM_LINES = 8,
   parameter int TAG_W     = 25,
   localparam int IDX_W    = $clog2(NUM_LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_all,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic             wr_valid,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic [TAG_W-1:0] rd_tag
);
   logic [NUM_LINES-1:0] valid_q;
   logic [TAG_W-1:0]     tag_q [NUM_LINES];

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q[g] <= 1'b0;
            tag_q[g]   <= '0;
         end else if (clr_all) begin
            valid_q[g] <= 1'b0;
         end else if (wr_en && (wr_idx == IDX_W'(g))) begin
            valid_q[g] <= wr_valid;
            tag_q[g]   <= wr_tag;
         end
      end
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/ifc_word_array.sv
module ifc_word_array #(
   parameter int NUM_LINES = 8,
   parameter int WORDS     = 4,
   parameter int DATA_W    = 32,
   localparam int IDX_W    = $clog2(NUM_LINES),
   localparam int OFS_W    = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [OFS_W-1:0]  wr_ofs,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [OFS_W-1:0]  rd_ofs,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem_q [NUM_LINES*WORDS];

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[{wr_idx, wr_ofs}] <= wr_data;
   end

   assign rd_data = mem_q[{rd_idx, rd_ofs}];
endmodule

// File: rtl/ifetch_cache.sv
module ifetch_cache
   import ifc_pkg::*;
#(
   parameter int          ADDR_W     = 32,
   parameter int          DATA_W     = 32,
   parameter int          NUM_LINES  = 8,
   parameter int          LINE_BYTES = 16,
   parameter logic [31:0] IO_BASE    = 32'hF000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              f_req,
   input  logic [ADDR_W-1:0] f_addr,
   output logic              f_ready,
   output logic              f_rvalid,
   output logic [DATA_W-1:0] f_rdata,
   output logic              f_rerr,
   output logic              bus_req,
   output logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_ack,
   input  logic              bus_err
);
   localparam int WORD_BYTES = DATA_W / 8;
   localparam int BYTE_W     = $clog2(WORD_BYTES);
   localparam int WORDS      = LINE_BYTES / WORD_BYTES;
   localparam int OFS_W      = $clog2(WORDS);
   localparam int IDX_W      = $clog2(NUM_LINES);
   localparam int TAG_W      = ADDR_W - IDX_W - OFS_W - BYTE_W;

   if ((NUM_LINES < 2) || ((NUM_LINES & (NUM_LINES - 1)) != 0)) begin : g_bad_lines
      $error("NUM_LINES must be a power of two and at least 2");
   end
   if ((LINE_BYTES < 2 * WORD_BYTES) || ((LINE_BYTES & (LINE_BYTES - 1)) != 0)) begin : g_bad_line
      $error("LINE_BYTES must be a power of two holding at least two words");
   end
   if ((DATA_W % 8 != 0) || (TAG_W < 1)) begin : g_bad_width
      $error("DATA_W must be whole bytes and ADDR_W must leave room for a tag");
   end

   ifc_state_e        state_q;
   logic              clr_pend_q;
   logic [IDX_W-1:0]  idx_q;
   logic [TAG_W-1:0]  tag_q;
   logic [OFS_W-1:0]  ofs_q;
   logic [OFS_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] direct_q;
   logic              rvalid_q;
   logic              rerr_q;
   logic [DATA_W-1:0] rdata_q;

   logic [IDX_W-1:0]  a_idx;
   logic [TAG_W-1:0]  a_tag;
   logic [OFS_W-1:0]  a_ofs;
   logic              a_io;
   logic              line_valid;
   logic [TAG_W-1:0]  line_tag;
   logic [DATA_W-1:0] line_word;
   logic              accept;
   logic              hit;
   logic              clear_now;
   logic              fill_ack;
   logic              fill_last;
   logic              tag_wr;
   logic              tag_wr_valid;

   assign a_ofs = f_addr[BYTE_W +: OFS_W];
   assign a_idx = f_addr[BYTE_W+OFS_W +: IDX_W];
   assign a_tag = f_addr[ADDR_W-1 -: TAG_W];
   assign a_io  = (f_addr >= ADDR_W'(IO_BASE));

   assign f_ready   = (state_q == ST_IDLE) && !clr_pend_q;
   assign accept    = f_req && f_ready;
   assign clear_now = (state_q == ST_IDLE) && (clr || clr_pend_q);
   assign hit       = line_valid && (line_tag == a_tag) && !clr;

   assign fill_ack  = (state_q == ST_FILL) && bus_ack;
   assign fill_last = (cnt_q == OFS_W'(WORDS - 1));

   // The line is written valid on the last good word and invalid on an error.
   assign tag_wr       = (state_q == ST_FILL) && (bus_err || (bus_ack && fill_last));
   assign tag_wr_valid = !bus_err;

   ifc_tag_array #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_all  (clear_now),
      .wr_en    (tag_wr),
      .wr_idx   (idx_q),
      .wr_tag   (tag_q),
      .wr_valid (tag_wr_valid),
      .rd_idx   (a_idx),
      .rd_valid (line_valid),
      .rd_tag   (line_tag)
   );

   ifc_word_array #(.NUM_LINES(NUM_LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_words (
      .clk     (clk),
      .wr_en   (fill_ack),
      .wr_idx  (idx_q),
      .wr_ofs  (cnt_q),
      .wr_data (bus_rdata),
      .rd_idx  (a_idx),
      .rd_ofs  (a_ofs),
      .rd_data (line_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clr_pend_q <= 1'b0;
      end else if (state_q != ST_IDLE) begin
         if (clr) clr_pend_q <= 1'b1;
      end else begin
         clr_pend_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         idx_q    <= '0;
         tag_q    <= '0;
         ofs_q    <= '0;
         cnt_q    <= '0;
         direct_q <= '0;
         rvalid_q <= 1'b0;
         rerr_q   <= 1'b0;
         rdata_q  <= '0;
      end else begin
         rvalid_q <= 1'b0;
         rerr_q   <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  if (a_io) begin
                     direct_q <= f_addr;
                     state_q  <= ST_DIRECT;
                  end else if (hit) begin
                     rvalid_q <= 1'b1;
                     rdata_q  <= line_word;
                  end else begin
                     idx_q   <= a_idx;
                     tag_q   <= a_tag;
                     ofs_q   <= a_ofs;
                     cnt_q   <= '0;
                     state_q <= ST_FILL;
                  end
               end
            end
            ST_FILL: begin
               if (bus_err) begin
                  rvalid_q <= 1'b1;
                  rerr_q   <= 1'b1;
                  state_q  <= ST_IDLE;
               end else if (bus_ack) begin
                  if (cnt_q == ofs_q) rdata_q <= bus_rdata;
                  cnt_q <= cnt_q + 1'b1;
                  if (fill_last) begin
                     rvalid_q <= 1'b1;
                     state_q  <= ST_IDLE;
                  end
               end
            end
            ST_DIRECT: begin
               if (bus_ack || bus_err) begin
                  rvalid_q <= 1'b1;
                  rerr_q   <= bus_err;
                  rdata_q  <= bus_rdata;
                  state_q  <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign f_rvalid = rvalid_q;
   assign f_rerr   = rerr_q;
   assign f_rdata  = rdata_q;
   assign bus_req  = (state_q != ST_IDLE);
   assign bus_addr = (state_q == ST_FILL) ? {tag_q, idx_q, cnt_q, BYTE_W'(0)} : direct_q;
endmodule

// File: rtl/ifc_checker.sv
module ifc_checker #(
   parameter int          ADDR_W  = 32,
   parameter logic [31:0] IO_BASE = 32'hF000_0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              f_req,
   input logic              f_ready,
   input logic              f_rvalid,
   input logic              f_rerr,
   input logic              bus_req,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_ack,
   input logic              bus_err
);
   logic [1:0] open_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) open_q <= '0;
      else open_q <= open_q + 2'((f_req && f_ready) ? 1 : 0) - 2'(f_rvalid ? 1 : 0);
   end

   // R1
   resp_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      f_rvalid |-> (open_q != 2'd0));

   // R2
   bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack && !bus_err) |=> (bus_req && $stable(bus_addr)));

   // R2
   word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && (bus_addr < ADDR_W'(IO_BASE))) |-> (bus_addr[1:0] == 2'b00));

   // R8
   err_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      f_rerr |-> f_rvalid);

   // R10
   busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> !f_ready);
endmodule

bind ifetch_cache ifc_checker #(.ADDR_W(ADDR_W), .IO_BASE(IO_BASE)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .f_req    (f_req),
   .f_ready  (f_ready),
   .f_rvalid (f_rvalid),
   .f_rerr   (f_rerr),
   .bus_req  (bus_req),
   .bus_addr (bus_addr),
   .bus_ack  (bus_ack),
   .bus_err  (bus_err)
);

// File: tb/sim_ifetch_cache.sv
`timescale 1ns/1ps
module sim_ifetch_cache;
   localparam int LINES = 8;
   localparam int LBYTES = 16;
   localparam int WORDS = LBYTES / 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic        f_req = 1'b0;
   logic [31:0] f_addr = '0;
   logic        f_ready, f_rvalid, f_rerr, bus_req;
   logic [31:0] f_rdata, bus_addr;
   logic [31:0] bus_rdata = '0;
   logic        bus_ack = 1'b0;
   logic        bus_err = 1'b0;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;
   bit expect_resp = 1'b0;
   int resp_lat = 0;
   int wcnt = 0;
   logic [31:0] err_addr = 32'h0000_0001;
   logic [31:0] txq[$];
   bit  mvalid[LINES];
   int  mtag[LINES];
   bit  clr_seen = 1'b0;

   always #2 clk = ~clk;

   ifetch_cache #(.NUM_LINES(LINES), .LINE_BYTES(LBYTES)) u0 (
      .clk(clk), .rst_n(rst_n), .clr(clr), .f_req(f_req), .f_addr(f_addr),
      .f_ready(f_ready), .f_rvalid(f_rvalid), .f_rdata(f_rdata), .f_rerr(f_rerr),
      .bus_req(bus_req), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
      .bus_ack(bus_ack), .bus_err(bus_err)
   );

   function automatic logic [31:0] mem_val(input logic [31:0] a);
      return {a[15:0], ~a[31:16]} ^ 32'h3C5A_0F1E;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Bus memory model: answers after resp_lat wait cycles, one cycle pulse.
   always @(negedge clk) begin
      if (!rst_n) begin
         bus_ack = 1'b0; bus_err = 1'b0; wcnt = 0;
      end else if (bus_ack || bus_err) begin
         bus_ack = 1'b0; bus_err = 1'b0; wcnt = 0;
      end else if (bus_req) begin
         if (wcnt >= resp_lat) begin
            bus_rdata = mem_val(bus_addr);
            if (bus_addr == err_addr) bus_err = 1'b1;
            else bus_ack = 1'b1;
            txq.push_back(bus_addr);
         end else begin
            wcnt++;
         end
      end
   end

   // Per-clock comparison: no response may appear when the model expects none.
   always @(negedge clk) begin
      cycles++;
      if (rst_n && f_rvalid && !expect_resp) begin
         errors++;
         $display("FAIL R1 unexpected response: actual 1 expected 0");
      end
      if (cycles > 100000 && !done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic fetch(input logic [31:0] a, input string req);
      logic [31:0] exp_tx[$];
      bit io, hit, eerr;
      int idx, tg, lat;
      logic [31:0] base;
      io  = (a >= 32'hF000_0000);
      idx = int'((a / LBYTES) % LINES);
      tg  = int'(a / (LBYTES * LINES));
      hit = !io && mvalid[idx] && (mtag[idx] == tg);
      eerr = 1'b0;
      if (io) begin
         exp_tx.push_back(a);
         eerr = (a == err_addr);
      end else if (!hit) begin
         base = a & ~32'(LBYTES - 1);
         for (int w = 0; w < WORDS; w++) begin
            exp_tx.push_back(base + 32'(4 * w));
            if (base + 32'(4 * w) == err_addr) begin
               eerr = 1'b1;
               break;
            end
         end
         mvalid[idx] = !eerr;
         mtag[idx]   = tg;
      end
      @(negedge clk);
      while (!f_ready) @(negedge clk);
      txq.delete();
      f_req = 1'b1; f_addr = a; expect_resp = 1'b1;
      @(negedge clk);
      f_req = 1'b0;
      lat = 1;
      while (!f_rvalid && lat < 400) begin
         @(negedge clk);
         lat++;
      end
      chk(f_rvalid, req, "response arrives", 32'(f_rvalid), 32'd1);
      chk(f_rerr == eerr, req, "error flag", 32'(f_rerr), 32'(eerr));
      if (!eerr) chk(f_rdata == mem_val(a), req, "data", f_rdata, mem_val(a));
      if (hit) chk(lat == 1, req, "hit latency", 32'(lat), 32'd1);
      chk(txq.size() == exp_tx.size(), req, "bus read count",
          32'(txq.size()), 32'(exp_tx.size()));
      for (int i = 0; i < exp_tx.size() && i < txq.size(); i++)
         chk(txq[i] == exp_tx[i], req, "bus address order", txq[i], exp_tx[i]);
      @(negedge clk);
      expect_resp = 1'b0;
      if (clr_seen) begin
         for (int l = 0; l < LINES; l++) mvalid[l] = 1'b0;
         clr_seen = 1'b0;
      end
   endtask

   task automatic pulse_clr();
      @(negedge clk);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      for (int l = 0; l < LINES; l++) mvalid[l] = 1'b0;
   endtask

   initial begin
      for (int l = 0; l < LINES; l++) begin mvalid[l] = 1'b0; mtag[l] = 0; end
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(f_ready == 1'b1, "R10", "ready after reset", 32'(f_ready), 32'd1);
      chk(f_rvalid == 1'b0, "R10", "no response in reset", 32'(f_rvalid), 32'd0);
      chk(bus_req == 1'b0, "R10", "no bus read in reset", 32'(bus_req), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      fetch(32'h0000_0104, "R2");          // cold miss, whole line from 0x100
      fetch(32'h0000_010C, "R3");          // other word of same line hits
      fetch(32'h0000_0100, "R1");          // hit, one cycle
      resp_lat = 2;
      fetch(32'h0000_0188, "R4");          // same index 0, new tag
      fetch(32'h0000_0104, "R4");          // evicted: misses again
      fetch(32'hF000_0010, "R5");          // uncached single read
      fetch(32'hF000_0010, "R5");          // not allocated: bus again
      resp_lat = 0;
      fetch(32'hFFFF_FFFC, "R5");
      pulse_clr();                          // R6 idle clear
      fetch(32'h0000_0108, "R6");
      err_addr = 32'h0000_0208;
      fetch(32'h0000_0200, "R8");          // error on third word
      fetch(32'h0000_0204, "R8");          // line stayed invalid
      err_addr = 32'h0000_0001;
      fetch(32'h0000_0204, "R8");          // clean refill
      fetch(32'h0000_020C, "R8");          // now a hit
      err_addr = 32'hF000_0020;
      fetch(32'hF000_0020, "R9");
      err_addr = 32'h0000_0001;
      fetch(32'h0000_0040, "R6");          // fill line 4, then keep it
      fork
         fetch(32'h0000_0300, "R7");
         begin
            repeat (3) @(negedge clk);
            chk(f_ready == 1'b0, "R10", "not ready during fill", 32'(f_ready), 32'd0);
            clr = 1'b1; clr_seen = 1'b1;
            @(negedge clk);
            clr = 1'b0;
         end
      join
      fetch(32'h0000_0300, "R7");          // invalidated after fill: miss
      fetch(32'h0000_0040, "R7");          // other lines cleared too
      chk(1'b1, "R1", "no spurious responses seen", 32'd0, 32'd0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule